// File: doc/BRIEF.md
# Double-Buffered Multichannel Converter Code Bank

This block is the clocked digital front end of an eight-channel, 14-bit converter that is written over a parallel bus. Each channel keeps two registers. A staging register is loaded from the data bus when chip-select and write are both low. A live register holds the code the converter actually uses. A single shared load strobe copies every staging register into its live register in the same cycle. This lets software prepare new codes for many channels one at a time and then change all of them together.

When chip-select, write and load are all low in the same cycle, the bus value reaches the addressed channel's live register at that same edge. A clear strobe raises a forced flag on every channel, which tells the analog side to drive its ground level. Clear leaves every stored code as it is, so the previous outputs return when clear is released. Codes are offset binary. The block samples every strobe on the rising clock edge. All of its outputs come straight from registers.

Top module: `dbl_buf_dac_bank`

## Requirements
- R1: A synchronous active-high reset sets every staging and live register to 0x0000 and clears every forced flag. All of this is visible one edge after reset is sampled high.
- R2: On an edge where cs_n=0 and wr_n=0, the staging register selected by `addr` (value k selects channel k, bits [14k+13:14k] of `code_o`) takes `din`.
- R3: On an edge where cs_n=1 or wr_n=1, no staging register changes, whatever `addr` and `din` carry.
- R4: A write changes only the addressed channel. The other seven staging registers keep their values.
- R5: While ld_n=1 every live register holds, so `code_o` does not change even while staging registers are written.
- R6: On an edge where ld_n=0, every live register takes the value its staging register has after that same edge. `code_o` shows it one edge later.
- R7: On an edge where cs_n, wr_n and ld_n are all 0, the addressed channel's field of `code_o` equals `din` after that single edge.
- R8: On an edge where clr_n=0, all bits of `forced_o` go to 1. On an edge where clr_n=1, they all go to 0. Clear changes no staging or live register, so codes return unchanged after release.
- R9: Codes pass unaltered in offset binary: 0x0000 is the lowest output, 0x2000 is mid-scale and 0x3FFF is the highest. All three reach `code_o` bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Global load strobe, level active low |
| clr_n | input | 1 | Global clear, active low |
| addr | input | 3 | Channel select for writes |
| din | input | 14 | Write data, offset binary |
| code_o | output | 112 | Live codes, channel k in bits [14k+13:14k] |
| forced_o | output | 8 | Per-channel forced-to-ground flag |

## Verification
Every result of this block appears exactly one rising edge after its stimulus is sampled. This covers a write into staging, a copy into the live registers, a write that passes straight through, and a change of the forced flags. The one exception is a staged write with load held high: it stays invisible until a later load edge, and it then appears one edge after that load. The bench drives each stimulus at a falling edge and updates its reference model at the following rising edge. It then compares all eight codes and the flag vector at the next falling edge, half a period after the outputs settle.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  localparam int unsigned DEF_CHANNELS = 8;
  localparam int unsigned DEF_CODE_W   = 14;

  // per-channel update choice for a live register
  typedef enum logic [1:0] {
    LIVE_HOLD   = 2'b00,
    LIVE_COPY   = 2'b01,
    LIVE_BYPASS = 2'b10
  } live_mode_e;
endpackage

// File: rtl/dbb_input_bank.sv
module dbb_input_bank #(
  parameter int unsigned NCH    = dbb_pkg::DEF_CHANNELS,
  parameter int unsigned CODE_W = dbb_pkg::DEF_CODE_W,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [CODE_W-1:0]       din,
  output logic [NCH-1:0]          wr_hit,
  output logic [NCH*CODE_W-1:0]   stage_flat
);
  logic wr_en;

  assign wr_en = ~cs_n & ~wr_n;

  // one-hot write decode; out-of-range addresses select nothing
  always_comb begin
    wr_hit = '0;
    for (int i = 0; i < NCH; i++) begin
      if (wr_en && (int'(addr) == i)) wr_hit[i] = 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_stage
    logic [CODE_W-1:0] stage_q;
    always_ff @(posedge clk) begin
      if (rst)            stage_q <= '0;
      else if (wr_hit[g]) stage_q <= din;
    end
    assign stage_flat[g*CODE_W +: CODE_W] = stage_q;
  end
endmodule

// File: rtl/dbb_output_bank.sv
module dbb_output_bank #(
  parameter int unsigned NCH    = dbb_pkg::DEF_CHANNELS,
  parameter int unsigned CODE_W = dbb_pkg::DEF_CODE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_n,
  input  logic [NCH-1:0]          wr_hit,
  input  logic [CODE_W-1:0]       din,
  input  logic [NCH*CODE_W-1:0]   stage_flat,
  output logic [NCH*CODE_W-1:0]   live_flat
);
  import dbb_pkg::*;

  for (genvar g = 0; g < NCH; g++) begin : g_live
    live_mode_e        mode;
    logic [CODE_W-1:0] live_q;

    always_comb begin
      if (ld_n)           mode = LIVE_HOLD;
      else if (wr_hit[g]) mode = LIVE_BYPASS;
      else                mode = LIVE_COPY;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        live_q <= '0;
      end else begin
        case (mode)
          LIVE_BYPASS: live_q <= din;
          LIVE_COPY:   live_q <= stage_flat[g*CODE_W +: CODE_W];
          default:     live_q <= live_q;
        endcase
      end
    end
    assign live_flat[g*CODE_W +: CODE_W] = live_q;
  end
endmodule

// File: rtl/dbb_clear_flags.sv
module dbb_clear_flags #(
  parameter int unsigned NCH = dbb_pkg::DEF_CHANNELS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_n,
  output logic [NCH-1:0] forced
);
  for (genvar g = 0; g < NCH; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) forced[g] <= 1'b0;
      else     forced[g] <= ~clr_n;
    end
  end
endmodule

// File: rtl/dbl_buf_dac_bank.sv
module dbl_buf_dac_bank #(
  parameter int unsigned NCH    = dbb_pkg::DEF_CHANNELS,
  parameter int unsigned CODE_W = dbb_pkg::DEF_CODE_W,
  localparam int unsigned ADDR_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned BUS_W  = NCH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] din,
  output logic [BUS_W-1:0]  code_o,
  output logic [NCH-1:0]    forced_o
);
  logic [NCH-1:0]   wr_hit;
  logic [BUS_W-1:0] stage_flat;

  dbb_input_bank #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_in (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .din(din),
    .wr_hit(wr_hit), .stage_flat(stage_flat)
  );

  dbb_output_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .ld_n(ld_n), .wr_hit(wr_hit), .din(din),
    .stage_flat(stage_flat), .live_flat(code_o)
  );

  dbb_clear_flags #(.NCH(NCH)) u_clr (
    .clk(clk), .rst(rst), .clr_n(clr_n), .forced(forced_o)
  );
endmodule

// File: rtl/dbb_checker.sv
module dbb_checker #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned CODE_W = 14,
  parameter int unsigned ADDR_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cs_n,
  input logic                  wr_n,
  input logic                  ld_n,
  input logic                  clr_n,
  input logic [ADDR_W-1:0]     addr,
  input logic [CODE_W-1:0]     din,
  input logic [NCH*CODE_W-1:0] code_o,
  input logic [NCH-1:0]        forced_o
);
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (code_o == '0) && (forced_o == '0)); // R1

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> $stable(code_o)); // R5

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && !ld_n && (int'(addr) < NCH))
      |=> (code_o[int'($past(addr))*CODE_W +: CODE_W] == $past(din))); // R7

  AST_CLR_FORCES: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (forced_o == {NCH{1'b1}})); // R8

  AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    clr_n |=> (forced_o == '0)); // R8
endmodule

bind dbl_buf_dac_bank dbb_checker #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
  .addr(addr), .din(din), .code_o(code_o), .forced_o(forced_o)
);

// File: tb/dbl_buf_dac_bank_test.sv
`timescale 1ns/1ps
module dbl_buf_dac_bank_test;
  localparam int NCH = 8;
  localparam int CW  = 14;

  logic clk = 1'b0;
  logic rst, cs_n, wr_n, ld_n, clr_n;
  logic [2:0] addr;
  logic [CW-1:0] din;
  logic [NCH*CW-1:0] code_o;
  logic [NCH-1:0] forced_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  int stage_m [NCH];
  int live_m  [NCH];
  bit forced_m;

  always #10 clk = ~clk;

  dbl_buf_dac_bank uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
    .addr(addr), .din(din), .code_o(code_o), .forced_o(forced_o)
  );

  task automatic compare_all(input string tag);
    for (int k = 0; k < NCH; k++) begin
      compared++;
      if (int'(code_o[k*CW +: CW]) != live_m[k]) begin
        mismatched++;
        $display("FAIL %s ch%0d code actual=%h expected=%h", tag, k,
                 code_o[k*CW +: CW], live_m[k]);
      end
    end
    compared++;
    if (forced_o != {NCH{forced_m}}) begin
      mismatched++;
      $display("FAIL %s forced actual=%b expected=%b", tag, forced_o, {NCH{forced_m}});
    end
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input bit r, input bit cs, input bit wr, input bit ld,
                      input bit cl, input int a, input int d, input string tag);
    rst = r; cs_n = cs; wr_n = wr; ld_n = ld; clr_n = cl;
    addr = 3'(a); din = CW'(d);
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < NCH; k++) begin stage_m[k] = 0; live_m[k] = 0; end
      forced_m = 0;
    end else begin
      if (!cs && !wr) stage_m[a] = d & 16'h3FFF;
      if (!ld) for (int k = 0; k < NCH; k++) live_m[k] = stage_m[k];
      forced_m = !cl;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1; cs_n = 1; wr_n = 1; ld_n = 1; clr_n = 1; addr = 0; din = 0;
    @(negedge clk);
    step(1, 1, 1, 1, 1, 0, 0, "R1");
    step(0, 1, 1, 1, 1, 0, 0, "R1");

    // R2 / R5: staged writes invisible while load is high
    for (int k = 0; k < NCH; k++) step(0, 0, 0, 1, 1, k, 100 + 37 * k, "R5");
    // R3: writes with one strobe high are ignored
    step(0, 1, 0, 1, 1, 3, 14'h1234, "R3");
    step(0, 0, 1, 1, 1, 4, 14'h0ABC, "R3");
    // R6 / R4: global copy exposes staged values, ch3/ch4 unchanged
    step(0, 1, 1, 0, 1, 0, 0, "R6");
    step(0, 1, 1, 1, 1, 0, 0, "R4");
    // R4: single write then load, others untouched
    step(0, 0, 0, 1, 1, 5, 14'h0777, "R4");
    step(0, 1, 1, 0, 1, 0, 0, "R4");

    // R9: offset-binary extremes and mid-scale
    step(0, 0, 0, 1, 1, 0, 14'h0000, "R9");
    step(0, 0, 0, 1, 1, 1, 14'h2000, "R9");
    step(0, 0, 0, 1, 1, 2, 14'h3FFF, "R9");
    step(0, 1, 1, 0, 1, 0, 0, "R9");

    // R7: all strobes low, data passes straight through
    step(0, 0, 0, 0, 1, 6, 14'h1111, "R7");
    step(0, 0, 0, 0, 1, 6, 14'h2222, "R7");
    step(0, 0, 0, 0, 1, 7, 14'h3ABC, "R7");
    step(0, 0, 0, 0, 1, 0, 14'h0001, "R7");

    // R8: clear raises flags, registers keep working and hold values
    step(0, 1, 1, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 2, 14'h0055, "R8");
    step(0, 1, 1, 1, 0, 0, 0, "R8");
    step(0, 1, 1, 1, 1, 0, 0, "R8");
    step(0, 1, 1, 0, 1, 0, 0, "R8");

    // R1: reset mid-run
    step(1, 0, 0, 0, 0, 3, 14'h3FFF, "R1");
    step(0, 1, 1, 1, 1, 0, 0, "R1");

    // R2: mixed random traffic
    for (int n = 0; n < 400; n++) begin
      step(0, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 4) != 0),
           $urandom_range(0, 7), $urandom_range(0, 16383), "R2");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule